// File: doc/BRIEF.md
# PWM Time-Base Counter with Two-Stage Prescaler

This block is the timing core of a pulse-width modulation generator. It holds a control word and a period value, both written through a small register write port, and it produces a counter value plus two event strobes. A user of the block reads the counter and the strobes to build PWM waveforms. Compare logic and output actions are not part of it.

The module clock passes through a two-stage prescaler, and the prescaler's output tick drives the counter. The control word selects one of four count modes: up, down, up-down or frozen. It also selects whether a period write goes straight into the active register or waits in a shadow copy. A run field lets the counter halt at once, halt at the end of the current cycle, or keep running.

A step is a single move of the counter. It happens only on a prescaler tick, when the run field allows it and the mode is not frozen. The zero event and the period event are registered. Each one is high for exactly one module clock, and that clock is the one in which the new counter value first appears.

Top module: `pwm_timebase`

## Requirements
- R1: After reset the counter reads 0 and both event strobes are low. The control word and both period copies are also 0, so the counter is halted, in up mode, with shadow loading.
- R2: In up mode (control bits 1:0 = 00), a step that starts from a count at or above the active period makes the count 0. Any other step adds 1.
- R3: In down mode (control bits 1:0 = 01), a step that starts from 0 loads the active period. Any other step subtracts 1.
- R4: In up-down mode (control bits 1:0 = 10), the counter climbs to the active period and then descends to 0. Its direction reverses on the step that lands on either end, so each end value appears once per turn.
- R5: In frozen mode (control bits 1:0 = 11), the count never changes and neither event strobe fires.
- R6: The prescaler issues a tick once every A·B module clocks. A is 2 to the power of control bits 12:10. B is 1 when control bits 9:7 are zero, and otherwise twice their value. Every control write restarts the prescaler, so the first tick with the new divisor comes A·B clocks after the write.
- R7: With control bit 3 = 0, a period write goes only to the shadow copy. The active period takes the shadow value on a step whose new count is 0.
- R8: With control bit 3 = 1, a period write sets the active period and the shadow copy together. The new value is in effect from the very next clock.
- R9: Control bits 15:14 select the run behaviour. With 00 no step occurs. With 01 the counter keeps stepping until a step lands on 0, then holds there until the next control write. With 10 or 11 the counter runs freely.
- R10: Both strobes fire only in the clock after a step, and each lasts one clock. The zero event fires when the new count is 0. The period event fires when the new count equals the active period as it stood before that step.
- R11: A write with wrSel = 0 replaces the control word and leaves both period copies alone. A write with wrSel = 1 writes the period and leaves the control word alone.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 1 | Write target: 0 control word, 1 period |
| wrData | input | CNT_W | Write data; the control word uses bits 15:0 |
| count | output | CNT_W | Present counter value |
| zeroEvt | output | 1 | One-clock strobe: the counter has just stepped to 0 |
| periodEvt | output | 1 | One-clock strobe: the counter has just stepped to the period |

## Verification
Two situations are the hardest to reach from the ports. The first is a shadow period waiting while the counter is partway through a cycle. The second is the halt that the stop-at-cycle-end setting latches on the step that lands on zero. The stimulus reaches the first by writing a new period in shadow mode in the middle of a cycle. It reaches the second by switching to stop-at-cycle-end while the counter is mid-count, and later lowering the period below the current count in immediate mode, which forces the wrap branch. A behavioural model in the bench follows every clock, so each of these boundaries is compared in the clock where it occurs, and so is the divisor of 1792, the largest the prescaler allows.

// File: rtl/tbase_pkg.sv
package tbase_pkg;
  // control word field positions
  localparam int MODE_LSB = 0;
  localparam int LOAD_BIT = 3;
  localparam int HSP_LSB  = 7;
  localparam int HSP_W    = 3;
  localparam int CDV_LSB  = 10;
  localparam int CDV_W    = 3;
  localparam int RUN_LSB  = 14;

  // largest total division: 2^(2^CDV_W-1) * 2*(2^HSP_W-1)
  localparam int unsigned MAX_DIV = (32'd1 << ((1 << CDV_W) - 1)) * (2 * ((1 << HSP_W) - 1));
  localparam int PRE_W = $clog2(MAX_DIV);

  typedef enum logic [1:0] {
    CM_UP   = 2'b00,
    CM_DOWN = 2'b01,
    CM_UPDN = 2'b10,
    CM_HOLD = 2'b11
  } cntMode_e;

  typedef struct packed {
    logic step;   // counter advances this clock
    logic ctlWr;  // control word written this clock
  } tbStrobe_t;
endpackage

// File: rtl/tbase_ctrl.sv
module tbase_ctrl
  import tbase_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             wrSel,
  input  logic [CNT_W-1:0] wrData,
  input  logic             landZero,
  output tbStrobe_t        strobe,
  output cntMode_e         countMode,
  output logic             loadImm
);
  logic [15:0]      ctlQ;
  logic [PRE_W-1:0] preQ;
  logic [PRE_W-1:0] divM1;
  logic             haltQ;
  logic             tick;
  logic             allowed;
  logic [1:0]       runSel;
  logic [CDV_W-1:0] cdv;
  logic [HSP_W-1:0] hsp;
  int unsigned      stageA, stageB, prod;

  assign countMode = cntMode_e'(ctlQ[MODE_LSB +: 2]);
  assign loadImm   = ctlQ[LOAD_BIT];
  assign runSel    = ctlQ[RUN_LSB +: 2];
  assign cdv       = ctlQ[CDV_LSB +: CDV_W];
  assign hsp       = ctlQ[HSP_LSB +: HSP_W];

  always_comb begin
    stageA = 32'd1 << cdv;
    stageB = (hsp == '0) ? 32'd1 : 32'(hsp) * 32'd2;
    prod   = stageA * stageB;
    divM1  = PRE_W'(prod - 32'd1);
  end

  assign tick    = (preQ == divM1);
  assign allowed = runSel[1] | ((runSel == 2'b01) & ~haltQ);

  assign strobe.step  = tick & allowed & (countMode != CM_HOLD);
  assign strobe.ctlWr = wrEn & ~wrSel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlQ  <= '0;
      preQ  <= '0;
      haltQ <= 1'b0;
    end else begin
      if (strobe.ctlWr) begin
        ctlQ <= wrData[15:0];
        preQ <= '0;
      end else if (tick) begin
        preQ <= '0;
      end else begin
        preQ <= preQ + 1'b1;
      end
      if (strobe.ctlWr)
        haltQ <= 1'b0;
      else if (strobe.step && landZero && runSel == 2'b01)
        haltQ <= 1'b1;
    end
  end

  // R6: a tick is never followed directly by another unless the divisor is one
  assert_tick_spacing_R6: assert property (@(posedge clk) disable iff (!rstN)
    (tick && divM1 != '0 && !strobe.ctlWr) |=> !tick);

  // R9: a latched halt stays until the control word is written
  assert_halt_holds_R9: assert property (@(posedge clk) disable iff (!rstN)
    (haltQ && !strobe.ctlWr) |=> haltQ);
endmodule

// File: rtl/tbase_dp.sv
module tbase_dp
  import tbase_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  tbStrobe_t        strobe,
  input  cntMode_e         countMode,
  input  logic             loadImm,
  input  logic             prdWr,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] cntQ,
  output logic             zeroEvt,
  output logic             periodEvt,
  output logic             landZero
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] prdQ, shdQ, nextCnt;
  logic             dirUpQ, nextDir;

  always_comb begin
    nextCnt = cntQ;
    nextDir = dirUpQ;
    unique case (countMode)
      CM_UP:   nextCnt = (cntQ >= prdQ) ? '0 : cntQ + ONE;
      CM_DOWN: nextCnt = (cntQ == '0) ? prdQ : cntQ - ONE;
      CM_UPDN: begin
        if (dirUpQ) begin
          if (cntQ >= prdQ) begin
            nextDir = 1'b0;
            nextCnt = (cntQ == '0) ? '0 : cntQ - ONE;
          end else begin
            nextCnt = cntQ + ONE;
            if (cntQ + ONE == prdQ) nextDir = 1'b0;
          end
        end else begin
          if (cntQ == '0) begin
            nextDir = 1'b1;
            nextCnt = (prdQ == '0) ? '0 : ONE;
          end else begin
            nextCnt = cntQ - ONE;
            if (cntQ == ONE) nextDir = 1'b1;
          end
        end
      end
      default: nextCnt = cntQ;
    endcase
  end

  assign landZero = (nextCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ      <= '0;
      dirUpQ    <= 1'b1;
      zeroEvt   <= 1'b0;
      periodEvt <= 1'b0;
      prdQ      <= '0;
      shdQ      <= '0;
    end else begin
      zeroEvt   <= strobe.step & landZero;
      periodEvt <= strobe.step & (nextCnt == prdQ);
      if (strobe.step) begin
        cntQ   <= nextCnt;
        dirUpQ <= nextDir;
      end
      if (prdWr) shdQ <= wrData;
      if (prdWr && loadImm) prdQ <= wrData;
      else if (strobe.step && landZero) prdQ <= shdQ;
    end
  end

  // R5: a frozen counter keeps its value
  assert_freeze_stable_R5: assert property (@(posedge clk) disable iff (!rstN)
    (countMode == CM_HOLD) |=> $stable(cntQ));

  // R2: up mode wraps to zero from the period
  assert_up_wrap_R2: assert property (@(posedge clk) disable iff (!rstN)
    (countMode == CM_UP && strobe.step && cntQ >= prdQ) |=> (cntQ == '0));

  // R8: an immediate period write is in effect at once
  assert_imm_load_R8: assert property (@(posedge clk) disable iff (!rstN)
    $past(prdWr && loadImm) |-> (prdQ == $past(wrData)));

  // R10: zero event only alongside a zero count, and only after a step
  assert_zero_evt_R10: assert property (@(posedge clk) disable iff (!rstN)
    zeroEvt |-> (cntQ == '0));
  assert_evt_step_R10: assert property (@(posedge clk) disable iff (!rstN)
    (zeroEvt || periodEvt) |-> $past(strobe.step));
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import tbase_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             wrSel,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] count,
  output logic             zeroEvt,
  output logic             periodEvt
);
  tbStrobe_t strobe;
  cntMode_e  countMode;
  logic      loadImm;
  logic      landZero;

  tbase_ctrl #(.CNT_W(CNT_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .landZero(landZero), .strobe(strobe), .countMode(countMode), .loadImm(loadImm)
  );

  tbase_dp #(.CNT_W(CNT_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .countMode(countMode),
    .loadImm(loadImm), .prdWr(wrEn & wrSel), .wrData(wrData),
    .cntQ(count), .zeroEvt(zeroEvt), .periodEvt(periodEvt), .landZero(landZero)
  );
endmodule

// File: tb/test_pwm_timebase.sv
`timescale 1ns/1ps
module test_pwm_timebase;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        wrSel = 1'b0;
  logic [15:0] wrData = '0;
  logic [15:0] count;
  logic        zeroEvt, periodEvt;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit checking = 1'b0;
  bit done = 1'b0;
  string curReq = "R1";

  // behavioural model state
  int mCtl, mPre, mHalt, mCnt, mPrd, mShd, mDirUp, mZ, mP;

  pwm_timebase #(.CNT_W(16)) i_pwm_timebase (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .count(count), .zeroEvt(zeroEvt), .periodEvt(periodEvt)
  );

  always #2 clk = ~clk;

  task automatic check(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    int divA, divB, run, mode, tick, step, nc, nd, oldPrd;
    if (!rstN) begin
      mCtl = 0; mPre = 0; mHalt = 0; mCnt = 0; mPrd = 0; mShd = 0;
      mDirUp = 1; mZ = 0; mP = 0;
    end else begin
      divA = 1 << ((mCtl >> 10) & 7);
      divB = ((mCtl >> 7) & 7) == 0 ? 1 : 2 * ((mCtl >> 7) & 7);
      run  = (mCtl >> 14) & 3;
      mode = mCtl & 3;
      tick = (mPre == divA * divB - 1);
      step = tick && (run >= 2 || (run == 1 && mHalt == 0)) && mode != 3;
      nc = mCnt; nd = mDirUp; oldPrd = mPrd;
      if (mode == 0) nc = (mCnt >= mPrd) ? 0 : mCnt + 1;
      else if (mode == 1) nc = (mCnt == 0) ? mPrd : mCnt - 1;
      else if (mode == 2) begin
        if (mDirUp != 0) begin
          if (mCnt >= mPrd) begin nd = 0; nc = (mCnt == 0) ? 0 : mCnt - 1; end
          else begin nc = mCnt + 1; if (nc == mPrd) nd = 0; end
        end else begin
          if (mCnt == 0) begin nd = 1; nc = (mPrd == 0) ? 0 : 1; end
          else begin nc = mCnt - 1; if (nc == 0) nd = 1; end
        end
      end
      mZ = (step && nc == 0) ? 1 : 0;
      mP = (step && nc == oldPrd) ? 1 : 0;
      if (step) begin mCnt = nc; mDirUp = nd; end
      if (wrEn && wrSel && ((mCtl >> 3) & 1) == 1) mPrd = int'(wrData);
      else if (step && nc == 0) mPrd = mShd;
      if (wrEn && wrSel) mShd = int'(wrData);
      if (wrEn && !wrSel) mHalt = 0;
      else if (step && nc == 0 && run == 1) mHalt = 1;
      if (wrEn && !wrSel) begin mCtl = int'(wrData); mPre = 0; end
      else if (tick) mPre = 0;
      else mPre = mPre + 1;
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (checking) begin
      check(curReq, "count", int'(count), mCnt);
      check(curReq, "zeroEvt", int'(zeroEvt), mZ);
      check(curReq, "periodEvt", int'(periodEvt), mP);
    end
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", cycles, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wr(bit sel, logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrSel = 1'b0; wrData = '0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    idle(4);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state seen directly at the ports
    check("R1", "reset count", int'(count), 0);
    check("R1", "reset zeroEvt", int'(zeroEvt), 0);
    check("R1", "reset periodEvt", int'(periodEvt), 0);
    checking = 1'b1;
    curReq = "R1"; idle(10);                  // stopped after reset
    curReq = "R11"; wr(0, 16'h0008); wr(1, 16'd5); idle(6);
    curReq = "R2";  wr(0, 16'hC008); idle(30);
    curReq = "R3";  wr(0, 16'hC009); idle(30);
    curReq = "R4";  wr(0, 16'hC00A); idle(40);
    curReq = "R5";  wr(0, 16'hC00B); idle(20);
    curReq = "R6";  wr(0, 16'hC988); idle(400);
    curReq = "R6";  wr(0, 16'hDF88); wr(1, 16'd2); idle(11000);
    curReq = "R7";  wr(0, 16'hC000); idle(3); wr(1, 16'd9); idle(50);
    curReq = "R8";  wr(0, 16'hC008); idle(6); wr(1, 16'd3); idle(20);
    curReq = "R4";  wr(0, 16'hC00A); wr(1, 16'd7); idle(40);
    curReq = "R9";  wr(0, 16'h4008); idle(30);
    curReq = "R9";  wr(0, 16'hC008); idle(2); wr(0, 16'h0008); idle(10);
    curReq = "R9";  wr(0, 16'h8008); idle(12);
    curReq = "R10"; wr(0, 16'hC009); wr(1, 16'd0); idle(10);
    curReq = "R10"; wr(0, 16'hC00A); idle(10);
    curReq = "R11"; wr(1, 16'h00C4); idle(20);
    curReq = "R10"; wr(0, 16'hC080); wr(1, 16'd2); idle(40);
    checking = 1'b0;
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule